// File: doc/BRIEF.md
# Oversampled Majority-Vote Bit Decoder

This receive-side block turns a serial bus line into frame bytes. The line is sampled eight times per bit. The samples are taken on a sample-clock enable and pass through a short shift window, and a majority vote over that window gives a cleaned bit level on every enabled sample. Falling edges of the voted level set the bit phase. A bit is taken near the end of each bit period. Each byte on the line starts with a high-then-low start sequence and is followed by eight data bits, most significant bit first. The decoder packs these bits and writes each finished byte out with a one-cycle write strobe, for a receive transit buffer.

The decoder does not stop when a protocol fault occurs. A wrong start sequence sets a coding flag. A reception that is still in progress at either edge of the slot sets a boundary flag. Bytes keep flowing while these flags are set. Access control marks the slot with a start strobe and an end strobe. At the end strobe the block decides whether the slot held one complete error-free frame, and it holds that verdict until the next slot starts. A frame is complete once the line has stayed high for eleven consecutive bit strobes. The line rate is chosen only by how often the sample enable is raised.

Top module: `ovs_bit_decoder`

## Requirements
- R1: On each cycle with `samp_en` high, the current `rx_line` value enters a five-sample window. The voted level is 1 when at least three of those five samples are 1. As a result, one or two inverted samples in the middle of a bit do not change any decoded byte.
- R2: A 1-to-0 change of the voted level resets the bit phase. A bit is taken on the fifth enabled sample after that change and then on every eighth enabled sample. A bit stretched by up to four extra samples is therefore absorbed at the next falling edge.
- R3: Each byte is a high bit, then a low bit, then eight data bits with the MSB first. Each complete byte appears on `byte_data` while `byte_wr` is high for exactly one cycle.
- R4: `err_coding` is set in the current slot if the start-sequence low bit is read as 1, if a falling edge arrives between bytes before any high bit has been taken, or if a 0 is taken where the start-sequence high bit is due.
- R5: A frame in progress ends on the eleventh consecutive strobed 1. After only ten such strobes, the frame is still in progress.
- R6: On `slot_end`, `frame_valid` goes high if a frame with at least one byte ended inside the slot, no error flag is set, and no reception is in progress. It stays high until the next `slot_start`. An empty slot leaves it low.
- R7: `err_boundary` is set when `slot_end` arrives during a reception. It is also set when `slot_start` arrives during a reception.
- R8: `slot_start` clears `frame_valid` and `err_coding`. Error flags never suppress `byte_wr`, and bytes received before an error are still written.
- R9: For a given sample stream, the decoded bytes and the verdict are the same whether `samp_en` is high every cycle, every second cycle or every fourth cycle.
- R10: After reset, `byte_wr`, `frame_valid`, `err_coding` and `err_boundary` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample-clock enable, eight per bit |
| rx_line | input | 1 | Raw receive line, synchronous to clk |
| slot_start | input | 1 | One-cycle strobe opening a slot |
| slot_end | input | 1 | One-cycle strobe closing a slot |
| byte_data | output | 8 | Last packed byte |
| byte_wr | output | 1 | One-cycle write strobe for byte_data |
| frame_valid | output | 1 | Slot verdict, held until next slot_start |
| err_coding | output | 1 | Start-sequence fault seen in this slot |
| err_boundary | output | 1 | Reception overlapped a slot edge |

## Verification
The hardest cases to reach from the ports are the bit-phase jumps, where a resynchronising edge must land after the strobe would otherwise have drifted out of the bit. These cases are reached by stretching each start-sequence high bit by four samples, which moves the free-running phase by half a bit before the falling edge pulls it back. Glitches of one and two samples are placed exactly where they land inside the vote window at strobe time. The end-of-frame rule is checked by closing the slot after exactly ten idle bits and after exactly eleven. A reception that opens before its slot is produced by starting a frame and then raising `slot_start` part-way through a byte.

// File: rtl/ovsdec_pkg.sv
package ovsdec_pkg;
  typedef enum logic [1:0] {
    DF_IDLE    = 2'd0,
    DF_SYNC_LO = 2'd1,
    DF_DATA    = 2'd2,
    DF_GAP     = 2'd3
  } df_state_e;
endpackage

// File: rtl/ovsdec_voter.sv
module ovsdec_voter #(
  parameter int VOTE_W  = 5,
  parameter int VOTE_TH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic rx_line,
  output logic vote_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(VOTE_W + 1);

  logic [VOTE_W-1:0] win_q, win_d;
  logic              lvl_q, lvl_d;
  logic [CNT_W-1:0]  ones;
  logic              vote_now;

  always_comb begin
    win_d = win_q;
    if (samp_en) win_d = {win_q[VOTE_W-2:0], rx_line};
    ones = '0;
    for (int i = 0; i < VOTE_W; i++) ones = ones + CNT_W'(win_d[i]);
    vote_now = (ones >= CNT_W'(VOTE_TH));
    lvl_d    = samp_en ? vote_now : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '1;
      lvl_q <= 1'b1;
    end else begin
      win_q <= win_d;
      lvl_q <= lvl_d;
    end
  end

  assign vote_o = vote_now;
  assign fall_o = samp_en & lvl_q & ~vote_now;

  p_unanimous_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && (&win_q) && rx_line) |=> lvl_q);
  p_unanimous_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && !(|win_q) && !rx_line) |=> !lvl_q);
endmodule

// File: rtl/ovsdec_bit_timer.sv
module ovsdec_bit_timer #(
  parameter int OVS       = 8,
  parameter int STROBE_AT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic fall_i,
  output logic strobe_o
);
  localparam int PH_W = $clog2(OVS);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (samp_en) begin
      if (fall_i)                         ph_d = '0;
      else if (ph_q == PH_W'(OVS - 1))    ph_d = '0;
      else                                ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign strobe_o = samp_en & ~fall_i & (ph_q == PH_W'(STROBE_AT - 1));

  p_strobe_on_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> samp_en);
  p_strobe_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/ovsdec_deframer.sv
module ovsdec_deframer
  import ovsdec_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              strobe_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_wr_o,
  output logic              cerr_o,
  output logic              frame_end_o,
  output logic              busy_o
);
  localparam int NB_W  = $clog2(DATA_W);
  localparam int RUN_W = $clog2(IDLE_BITS + 1);

  df_state_e         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d, byte_q, byte_d;
  logic [NB_W-1:0]   nbit_q, nbit_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic              gap_seen_q, gap_seen_d;
  logic              wr_q, wr_d, cerr_q, cerr_d, end_q, end_d;

  always_comb begin
    st_d       = st_q;
    sh_d       = sh_q;
    byte_d     = byte_q;
    nbit_d     = nbit_q;
    run_d      = run_q;
    gap_seen_d = gap_seen_q;
    wr_d       = 1'b0;
    cerr_d     = 1'b0;
    end_d      = 1'b0;

    if (strobe_i) begin
      if (!bit_i)                              run_d = '0;
      else if (run_q != RUN_W'(IDLE_BITS))     run_d = run_q + 1'b1;
    end

    case (st_q)
      DF_IDLE: begin
        if (fall_i) begin
          st_d       = DF_SYNC_LO;
          gap_seen_d = 1'b0;
        end
      end
      DF_SYNC_LO: begin
        if (strobe_i) begin
          if (bit_i) cerr_d = 1'b1;
          st_d   = DF_DATA;
          nbit_d = '0;
        end
      end
      DF_DATA: begin
        if (strobe_i) begin
          sh_d = {sh_q[DATA_W-2:0], bit_i};
          if (nbit_q == NB_W'(DATA_W - 1)) begin
            byte_d     = {sh_q[DATA_W-2:0], bit_i};
            wr_d       = 1'b1;
            st_d       = DF_GAP;
            gap_seen_d = 1'b0;
          end else begin
            nbit_d = nbit_q + 1'b1;
          end
        end
      end
      DF_GAP: begin
        if (fall_i) begin
          if (!gap_seen_q) cerr_d = 1'b1;
          st_d = DF_SYNC_LO;
        end else if (strobe_i) begin
          gap_seen_d = 1'b1;
          if (!bit_i) cerr_d = 1'b1;
        end
      end
      default: st_d = DF_IDLE;
    endcase

    if (st_q != DF_IDLE && strobe_i && bit_i && run_q == RUN_W'(IDLE_BITS - 1)) begin
      st_d   = DF_IDLE;
      end_d  = 1'b1;
      cerr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= DF_IDLE;
      sh_q       <= '0;
      byte_q     <= '0;
      nbit_q     <= '0;
      run_q      <= '0;
      gap_seen_q <= 1'b0;
      wr_q       <= 1'b0;
      cerr_q     <= 1'b0;
      end_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      sh_q       <= sh_d;
      byte_q     <= byte_d;
      nbit_q     <= nbit_d;
      run_q      <= run_d;
      gap_seen_q <= gap_seen_d;
      wr_q       <= wr_d;
      cerr_q     <= cerr_d;
      end_q      <= end_d;
    end
  end

  assign byte_o      = byte_q;
  assign byte_wr_o   = wr_q;
  assign cerr_o      = cerr_q;
  assign frame_end_o = end_q;
  assign busy_o      = (st_q != DF_IDLE);

  p_wr_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_o |-> (st_q == DF_GAP));
  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_o |=> !byte_wr_o);
  p_end_goes_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> (st_q == DF_IDLE));
  p_end_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> (run_q == RUN_W'(IDLE_BITS)));
endmodule

// File: rtl/ovsdec_slot_judge.sv
module ovsdec_slot_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_start_i,
  input  logic slot_end_i,
  input  logic busy_i,
  input  logic byte_wr_i,
  input  logic cerr_i,
  input  logic frame_end_i,
  output logic valid_o,
  output logic err_coding_o,
  output logic err_boundary_o
);
  logic open_q, open_d, seen_q, seen_d, got_q, got_d;
  logic code_q, code_d, bound_q, bound_d, valid_q, valid_d;
  logic code_nx, seen_nx, got_nx;

  always_comb begin
    open_d  = open_q;
    seen_d  = seen_q;
    got_d   = got_q;
    code_d  = code_q;
    bound_d = bound_q;
    valid_d = valid_q;
    code_nx = code_q | cerr_i;
    seen_nx = seen_q | byte_wr_i;
    got_nx  = got_q | (frame_end_i & seen_nx);

    if (slot_start_i) begin
      open_d  = 1'b1;
      seen_d  = 1'b0;
      got_d   = 1'b0;
      code_d  = 1'b0;
      bound_d = busy_i;
      valid_d = 1'b0;
    end else if (open_q) begin
      code_d = code_nx;
      seen_d = seen_nx;
      got_d  = got_nx;
      if (slot_end_i) begin
        open_d  = 1'b0;
        bound_d = bound_q | busy_i;
        valid_d = !busy_i && got_nx && !code_nx && !bound_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      seen_q  <= 1'b0;
      got_q   <= 1'b0;
      code_q  <= 1'b0;
      bound_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      seen_q  <= seen_d;
      got_q   <= got_d;
      code_q  <= code_d;
      bound_q <= bound_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o        = valid_q;
  assign err_coding_o   = code_q;
  assign err_boundary_o = bound_q;

  p_valid_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!err_coding_o && !err_boundary_o));
  p_slot_strobes_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_start_i && slot_end_i));
  p_busy_close_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_i && open_q && busy_i) |=> (err_boundary_o && !valid_o));
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start_i |=> (!valid_o && !err_coding_o));
endmodule

// File: rtl/ovs_bit_decoder.sv
module ovs_bit_decoder #(
  parameter int OVS       = 8,
  parameter int VOTE_W    = 5,
  parameter int VOTE_TH   = 3,
  parameter int STROBE_AT = 5,
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              rx_line,
  input  logic              slot_start,
  input  logic              slot_end,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_wr,
  output logic              frame_valid,
  output logic              err_coding,
  output logic              err_boundary
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  logic       vote, fall, strobe, busy, cerr, fend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  ovsdec_voter #(.VOTE_W(VOTE_W), .VOTE_TH(VOTE_TH)) u_voter (
    .clk(clk), .rst_n(rst_sn), .samp_en(samp_en), .rx_line(rx_line),
    .vote_o(vote), .fall_o(fall));

  ovsdec_bit_timer #(.OVS(OVS), .STROBE_AT(STROBE_AT)) u_timer (
    .clk(clk), .rst_n(rst_sn), .samp_en(samp_en), .fall_i(fall),
    .strobe_o(strobe));

  ovsdec_deframer #(.DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS)) u_deframer (
    .clk(clk), .rst_n(rst_sn), .fall_i(fall), .strobe_i(strobe), .bit_i(vote),
    .byte_o(byte_data), .byte_wr_o(byte_wr), .cerr_o(cerr),
    .frame_end_o(fend), .busy_o(busy));

  ovsdec_slot_judge u_judge (
    .clk(clk), .rst_n(rst_sn), .slot_start_i(slot_start), .slot_end_i(slot_end),
    .busy_i(busy), .byte_wr_i(byte_wr), .cerr_i(cerr), .frame_end_i(fend),
    .valid_o(frame_valid), .err_coding_o(err_coding),
    .err_boundary_o(err_boundary));
endmodule

// File: tb/ovs_bit_decoder_test.sv
`timescale 1ns/1ps
module ovs_bit_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n, samp_en, rx_line, slot_start, slot_end;
  logic [7:0] byte_data;
  logic       byte_wr, frame_valid, err_coding, err_boundary;

  always #2.5 clk = ~clk;

  ovs_bit_decoder uut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_line(rx_line),
    .slot_start(slot_start), .slot_end(slot_end), .byte_data(byte_data),
    .byte_wr(byte_wr), .frame_valid(frame_valid), .err_coding(err_coding),
    .err_boundary(err_boundary));

  int checks = 0;
  int fails  = 0;
  int div_g  = 1;
  int ncap   = 0;
  logic [7:0] cap [64];

  always @(negedge clk) begin
    if (byte_wr && ncap < 64) begin
      cap[ncap] = byte_data;
      ncap = ncap + 1;
    end
  end

  // fields: exp_valid, div, glitch mode, stretch, byte count, three bytes
  localparam logic [34:0] VEC [0:5] = '{
    {1'b1, 3'd1, 2'd0, 3'd0, 2'd3, 8'hA5, 8'h3C, 8'h0F},
    {1'b1, 3'd2, 2'd1, 3'd0, 2'd2, 8'h5A, 8'h80, 8'h00},
    {1'b1, 3'd4, 2'd2, 3'd0, 2'd3, 8'hFF, 8'h00, 8'h81},
    {1'b1, 3'd1, 2'd2, 3'd4, 2'd3, 8'h12, 8'h34, 8'h56},
    {1'b1, 3'd2, 2'd0, 3'd4, 2'd1, 8'hC3, 8'h00, 8'h00},
    {1'b1, 3'd1, 2'd1, 3'd0, 2'd2, 8'h7E, 8'hE7, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic smp(input logic b);
    rx_line = b;
    samp_en = 1'b1;
    @(negedge clk);
    samp_en = 1'b0;
    repeat (div_g - 1) @(negedge clk);
  endtask

  task automatic bitv(input logic b, input int gl, input int extra);
    for (int i = 0; i < 8 + extra; i++) begin
      logic s;
      s = b;
      if (gl == 1 && i == 5) s = ~b;
      if (gl == 2 && (i == 4 || i == 5)) s = ~b;
      smp(s);
    end
  endtask

  task automatic sbyte(input logic [7:0] v, input int gl, input int extra);
    bitv(1'b1, gl, extra);
    bitv(1'b0, gl, 0);
    for (int i = 7; i >= 0; i--) bitv(v[i], gl, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bitv(1'b1, 0, 0);
  endtask

  task automatic open_slot();
    slot_start = 1'b1;
    @(negedge clk);
    slot_start = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_slot();
    slot_end = 1'b1;
    @(negedge clk);
    slot_end = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all();
    int base;
    // R10: reset state
    chk("R10 byte_wr after reset", byte_wr, 0);
    chk("R10 frame_valid after reset", frame_valid, 0);
    chk("R10 err_coding after reset", err_coding, 0);
    chk("R10 err_boundary after reset", err_boundary, 0);

    // vector table: R1 glitches, R2 stretch, R3 packing, R9 rates, R6 verdict
    for (int k = 0; k < 6; k++) begin
      logic [34:0] v;
      logic [7:0]  eb [3];
      int          nb;
      v     = VEC[k];
      div_g = int'(v[33:31]);
      nb    = int'(v[25:24]);
      eb[0] = v[23:16];
      eb[1] = v[15:8];
      eb[2] = v[7:0];
      base  = ncap;
      open_slot();
      idle(2);
      for (int j = 0; j < nb; j++) sbyte(eb[j], int'(v[30:29]), int'(v[28:26]));
      idle(14);
      close_slot();
      chk($sformatf("R3 R9 byte count vec%0d", k), ncap - base, nb);
      for (int j = 0; j < nb; j++)
        chk($sformatf("R1 R2 R3 byte%0d vec%0d", j, k), cap[base + j], eb[j]);
      chk($sformatf("R6 frame_valid vec%0d", k), frame_valid, int'(v[34]));
      chk($sformatf("R4 err_coding vec%0d", k), err_coding, 0);
      chk($sformatf("R7 err_boundary vec%0d", k), err_boundary, 0);
    end
    div_g = 1;

    // R4, R8: missing start-sequence high bit
    base = ncap;
    open_slot();
    idle(2);
    sbyte(8'hA5, 0, 0);
    bitv(1'b0, 0, 0);
    bitv(1'b0, 0, 0);
    for (int i = 7; i >= 0; i--) bitv(i % 4 < 2, 0, 0);
    idle(14);
    close_slot();
    chk("R4 err_coding on bad start", err_coding, 1);
    chk("R6 frame_valid with coding fault", frame_valid, 0);
    chk("R8 byte before fault written", cap[base], 8'hA5);
    chk("R8 bytes still written", (ncap - base) >= 2, 1);
    open_slot();
    chk("R8 slot_start clears err_coding", err_coding, 0);
    chk("R8 slot_start clears frame_valid", frame_valid, 0);
    close_slot();
    chk("R6 empty slot not valid", frame_valid, 0);

    // R5, R7: close after ten idle bits -> still receiving
    open_slot();
    idle(2);
    sbyte(8'h42, 0, 0);
    idle(10);
    close_slot();
    chk("R5 R7 ten idle bits keep frame open", err_boundary, 1);
    chk("R5 ten idle bits not valid", frame_valid, 0);
    idle(3);
    open_slot();
    chk("R8 boundary flag cleared when idle", err_boundary, 0);

    // R5: eleven idle bits end the frame
    idle(1);
    sbyte(8'h42, 0, 0);
    idle(11);
    close_slot();
    chk("R5 eleven idle bits end frame", frame_valid, 1);
    chk("R5 no boundary flag", err_boundary, 0);

    // R7: slot opens in the middle of a reception
    idle(2);
    bitv(1'b1, 0, 0);
    bitv(1'b0, 0, 0);
    bitv(1'b1, 0, 0);
    bitv(1'b0, 0, 0);
    open_slot();
    chk("R7 slot_start during reception", err_boundary, 1);
    for (int i = 0; i < 6; i++) bitv(i[0], 0, 0);
    idle(14);
    close_slot();
    chk("R7 crossing frame not valid", frame_valid, 0);
    chk("R7 boundary flag held", err_boundary, 1);
  endtask

  initial begin
    logic timeout;
    timeout    = 1'b0;
    rst_n      = 1'b0;
    samp_en    = 1'b0;
    rx_line    = 1'b1;
    slot_start = 1'b0;
    slot_end   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule